// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block is a small first-in first-out store that decouples a 16-bit memory fetch path from a byte-oriented instruction decoder. The fetch side delivers one 16-bit word per fetch cycle, and both of its bytes are loaded in the same clock. The decoder side takes one byte per read, always the oldest byte held. The oldest byte sits in the slot nearest the output. When a byte is taken, every remaining byte moves one slot toward the output.

The block also decides when a new fetch may start. It raises a fetch request only while at least two byte slots are free, no operand access from the execution side is waiting, and no flush is being applied. In every other case the request stays low and the bus is left idle. A flush input, used on control transfers, empties the queue in one cycle. A level output reports how many bytes are held, and a one-cycle status pulse marks a read made while the queue was empty.

Top module: `prefetch_byte_queue`

## Requirements
- R1: After reset the level is 0, `rd_valid` and `full` are 0, `underflow` is 0, and `fetch_req` is 1 while `opnd_pend` and `flush` are low.
- R2: The queue holds at most DEPTH bytes (default 6). `full` is 1 exactly when the level equals DEPTH, and the level never exceeds DEPTH.
- R3: An accepted fill word loads two bytes in one cycle and adds 2 to the level. Bits [7:0] (the even-address byte) are presented on `rd_byte` before bits [15:8].
- R4: Bytes leave in strict arrival order across successive words. Each accepted read removes exactly one byte, and the next oldest byte appears on `rd_byte` in the following cycle.
- R5: `fetch_req` is 1 only while DEPTH minus level is at least 2, `opnd_pend` is 0 and `flush` is 0. With the default DEPTH it is 1 at level 4 and 0 at levels 5 and 6.
- R6: While `opnd_pend` is 1, `fetch_req` is 0 whatever the level.
- R7: A fill word that would not fit is dropped whole. Fit is judged after removing a same-cycle read, and the word fits when the level after that read is at most DEPTH-2. A dropped word leaves the level and the stored bytes unchanged, apart from the effect of the read.
- R8: An accepted fill and an accepted read in the same cycle change the level by exactly +1, and byte order is kept.
- R9: A cycle with `flush` at 1 sets the level to 0 at the next edge. Any fill word and any read presented in that cycle are discarded, and `fetch_req` is 0 during that cycle.
- R10: A read while the level is 0 changes nothing in the queue. `underflow` is 1 for exactly the one cycle after that read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fill_valid | input | 1 | A fetched word is present on `fill_word` this cycle |
| fill_word | input | 16 | Fetched word; [7:0] is the even-address byte |
| flush | input | 1 | Empty the queue and discard this cycle's fill and read |
| opnd_pend | input | 1 | The execution side is waiting for an operand bus cycle |
| rd_req | input | 1 | The decoder takes the byte on `rd_byte` at this edge |
| fetch_req | output | 1 | A new word fetch may start |
| rd_byte | output | 8 | Oldest byte held |
| rd_valid | output | 1 | `rd_byte` holds a valid byte |
| level | output | 3 | Number of bytes held |
| full | output | 1 | Level equals DEPTH |
| underflow | output | 1 | One-cycle pulse after a read made while empty |

## Verification
The bench builds the block with its default DEPTH of 6 and a 16-bit word. With these values the room boundary (levels 4, 5 and 6), the full state and the dropped-word case are each reached within three words. Every ordering case then stays short enough to check byte by byte against hand-computed sequences. The combined fill-and-read cycle is exercised both where it fits (level 5 to 6) and where it does not (level 6 to 5).

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int PFQ_DEPTH_DFLT = 6;
  localparam int PFQ_BYTE_W     = 8;
  localparam int PFQ_LANES      = 2;

  typedef struct packed {
    logic flush;
    logic rd_ok;
    logic wr_ok;
  } pfq_op_t;
endpackage

// File: rtl/pfq_rst_sync.sv
module pfq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pfq_level_ctrl.sv
module pfq_level_ctrl
  import pfq_pkg::*;
#(
  parameter int DEPTH = PFQ_DEPTH_DFLT,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_valid,
  input  logic             rd_req,
  input  logic             flush,
  output logic [LVL_W-1:0] level_q,
  output logic [LVL_W-1:0] wr_base,
  output pfq_op_t          op,
  output logic             underflow_q
);
  localparam logic [LVL_W-1:0] ROOM_MAX = LVL_W'(DEPTH - PFQ_LANES);

  logic [LVL_W-1:0] level_nxt;
  logic [LVL_W-1:0] after_rd;
  logic             uf_nxt;

  always_comb begin
    op.flush = flush;
    op.rd_ok = rd_req && (level_q != '0) && !flush;
    after_rd = level_q - {{(LVL_W-1){1'b0}}, op.rd_ok};
    op.wr_ok = fill_valid && !flush && (after_rd <= ROOM_MAX);
    wr_base  = after_rd;
    uf_nxt   = rd_req && (level_q == '0) && !flush;
    if (flush)          level_nxt = '0;
    else if (op.wr_ok)  level_nxt = after_rd + LVL_W'(PFQ_LANES);
    else                level_nxt = after_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q     <= '0;
      underflow_q <= 1'b0;
    end else begin
      level_q     <= level_nxt;
      underflow_q <= uf_nxt;
    end
  end
endmodule

// File: rtl/pfq_slot_array.sv
module pfq_slot_array
  import pfq_pkg::*;
#(
  parameter int DEPTH  = PFQ_DEPTH_DFLT,
  parameter int BYTE_W = PFQ_BYTE_W,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pfq_op_t           op,
  input  logic [LVL_W-1:0]  wr_base,
  input  logic [2*BYTE_W-1:0] word,
  output logic [BYTE_W-1:0] head
);
  logic [DEPTH-1:0][BYTE_W-1:0] slot_bus;
  logic [LVL_W-1:0]             hi_idx;
  logic                         shift;
  logic                         load;

  assign hi_idx = wr_base + 1'b1;
  assign shift  = op.rd_ok;
  assign load   = op.wr_ok;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [BYTE_W-1:0] q;
    logic [BYTE_W-1:0] d;
    logic [BYTE_W-1:0] from_up;
    logic              en;

    if (i < DEPTH - 1) begin : g_mid
      assign from_up = slot_bus[i+1];
    end else begin : g_top
      assign from_up = '0;
    end

    always_comb begin
      d = shift ? from_up : q;
      if (load && (wr_base == LVL_W'(i)))     d = word[BYTE_W-1:0];
      else if (load && (hi_idx == LVL_W'(i))) d = word[2*BYTE_W-1:BYTE_W];
      en = shift || load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign slot_bus[i] = q;
  end

  assign head = slot_bus[0];
endmodule

// File: rtl/pfq_req_gen.sv
module pfq_req_gen
  import pfq_pkg::*;
#(
  parameter int DEPTH = PFQ_DEPTH_DFLT,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0] level_q,
  input  logic             opnd_pend,
  input  logic             flush,
  output logic             fetch_req,
  output logic             full,
  output logic             rd_valid
);
  localparam logic [LVL_W-1:0] CAP = LVL_W'(DEPTH);

  logic [LVL_W-1:0] free_slots;

  always_comb begin
    free_slots = CAP - level_q;
    fetch_req  = (free_slots >= LVL_W'(PFQ_LANES)) && !opnd_pend && !flush;
    full       = (level_q == CAP);
    rd_valid   = (level_q != '0);
  end
endmodule

// File: rtl/prefetch_byte_queue.sv
module prefetch_byte_queue
  import pfq_pkg::*;
#(
  parameter int DEPTH  = PFQ_DEPTH_DFLT,
  parameter int BYTE_W = PFQ_BYTE_W,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fill_valid,
  input  logic [2*BYTE_W-1:0] fill_word,
  input  logic                flush,
  input  logic                opnd_pend,
  input  logic                rd_req,
  output logic                fetch_req,
  output logic [BYTE_W-1:0]   rd_byte,
  output logic                rd_valid,
  output logic [LVL_W-1:0]    level,
  output logic                full,
  output logic                underflow
);
  logic             srst_n;
  pfq_op_t          op;
  logic [LVL_W-1:0] wr_base;
  logic [LVL_W-1:0] level_q;

  pfq_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  pfq_level_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst_n       (srst_n),
    .fill_valid  (fill_valid),
    .rd_req      (rd_req),
    .flush       (flush),
    .level_q     (level_q),
    .wr_base     (wr_base),
    .op          (op),
    .underflow_q (underflow)
  );

  pfq_slot_array #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_slots (
    .clk     (clk),
    .rst_n   (srst_n),
    .op      (op),
    .wr_base (wr_base),
    .word    (fill_word),
    .head    (rd_byte)
  );

  pfq_req_gen #(.DEPTH(DEPTH)) u_req (
    .level_q   (level_q),
    .opnd_pend (opnd_pend),
    .flush     (flush),
    .fetch_req (fetch_req),
    .full      (full),
    .rd_valid  (rd_valid)
  );

  assign level = level_q;
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
  parameter int DEPTH = 6,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fill_valid,
  input logic             flush,
  input logic             opnd_pend,
  input logic             rd_req,
  input logic             fetch_req,
  input logic             full,
  input logic             underflow,
  input logic [LVL_W-1:0] level
);
  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= DEPTH);

  // R5
  no_req_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> !full);

  // R6
  opnd_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opnd_pend |-> !fetch_req);

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0));

  // R10
  underflow_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && level == '0 && !flush) |=> underflow);

  // R8
  net_plus_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && rd_req && !flush && level != '0 && int'(level) <= DEPTH - 1)
      |=> (int'(level) == int'($past(level)) + 1));
endmodule

bind prefetch_byte_queue pfq_checker #(.DEPTH(DEPTH)) u_pfq_chk (
  .clk        (clk),
  .rst_n      (srst_n),
  .fill_valid (fill_valid),
  .flush      (flush),
  .opnd_pend  (opnd_pend),
  .rd_req     (rd_req),
  .fetch_req  (fetch_req),
  .full       (full),
  .underflow  (underflow),
  .level      (level)
);

// File: tb/prefetch_byte_queue_bench.sv
`timescale 1ns/1ps
module prefetch_byte_queue_bench;
  logic        clk;
  logic        rst_n;
  logic        fill_valid;
  logic [15:0] fill_word;
  logic        flush;
  logic        opnd_pend;
  logic        rd_req;
  logic        fetch_req;
  logic [7:0]  rd_byte;
  logic        rd_valid;
  logic [2:0]  level;
  logic        full;
  logic        underflow;

  int checks = 0;
  int fails  = 0;

  prefetch_byte_queue u_prefetch_byte_queue (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_word(fill_word),
    .flush(flush), .opnd_pend(opnd_pend), .rd_req(rd_req),
    .fetch_req(fetch_req), .rd_byte(rd_byte), .rd_valid(rd_valid),
    .level(level), .full(full), .underflow(underflow)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic fv, input logic [15:0] w, input logic rd, input logic fl);
    fill_valid = fv; fill_word = w; rd_req = rd; flush = fl;
    @(posedge clk); #2;
    fill_valid = 1'b0; fill_word = '0; rd_req = 1'b0; flush = 1'b0;
    #1;
  endtask

  task automatic read_expect(input string tag, input logic [7:0] exp);
    chk(tag, rd_byte, exp);
    cyc(1'b0, 16'h0, 1'b1, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 level", level, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 full", full, 0);
    chk("R1 underflow", underflow, 0);
    chk("R1 fetch_req", fetch_req, 1);
  endtask

  task automatic t_order();
    cyc(1'b1, 16'hBBAA, 1'b0, 1'b0);
    chk("R3 level", level, 2);
    read_expect("R3 low byte first", 8'hAA);
    chk("R4 level after read", level, 1);
    read_expect("R3 high byte second", 8'hBB);
    chk("R4 empty", rd_valid, 0);
  endtask

  task automatic t_multi();
    cyc(1'b1, 16'h1122, 1'b0, 1'b0);
    cyc(1'b1, 16'h3344, 1'b0, 1'b0);
    chk("R5 req at level 4", fetch_req, 1);
    cyc(1'b1, 16'h5566, 1'b0, 1'b0);
    chk("R2 level full", level, 6);
    chk("R2 full flag", full, 1);
    chk("R5 no req when full", fetch_req, 0);
    read_expect("R4 b0", 8'h22);
    read_expect("R4 b1", 8'h11);
    read_expect("R4 b2", 8'h44);
    read_expect("R4 b3", 8'h33);
    read_expect("R4 b4", 8'h66);
    read_expect("R4 b5", 8'h55);
    chk("R4 drained", level, 0);
  endtask

  task automatic t_room_drop();
    cyc(1'b1, 16'h0201, 1'b0, 1'b0);
    cyc(1'b1, 16'h0403, 1'b0, 1'b0);
    cyc(1'b1, 16'h0605, 1'b0, 1'b0);
    cyc(1'b0, 16'h0, 1'b1, 1'b0);
    chk("R5 level 5", level, 5);
    chk("R5 no req at level 5", fetch_req, 0);
    cyc(1'b1, 16'hDEAD, 1'b0, 1'b0);
    chk("R7 drop keeps level", level, 5);
    chk("R7 drop keeps head", rd_byte, 8'h02);
    cyc(1'b1, 16'hBEEF, 1'b1, 1'b0);
    chk("R8 fill+read 5 to 6", level, 6);
    cyc(1'b1, 16'hCAFE, 1'b1, 1'b0);
    chk("R7 drop with read 6 to 5", level, 5);
    read_expect("R7 c0", 8'h04);
    read_expect("R7 c1", 8'h05);
    read_expect("R7 c2", 8'h06);
    read_expect("R8 c3", 8'hEF);
    read_expect("R8 c4", 8'hBE);
    chk("R7 drained", level, 0);
  endtask

  task automatic t_opnd();
    opnd_pend = 1'b1; #1;
    chk("R6 req blocked empty", fetch_req, 0);
    cyc(1'b1, 16'h2211, 1'b0, 1'b0);
    chk("R6 req blocked level 2", fetch_req, 0);
    opnd_pend = 1'b0; #1;
    chk("R6 req back", fetch_req, 1);
  endtask

  task automatic t_simul();
    cyc(1'b1, 16'h4433, 1'b1, 1'b0);
    chk("R8 level 2 to 3", level, 3);
    read_expect("R8 s0", 8'h22);
    read_expect("R8 s1", 8'h33);
    read_expect("R8 s2", 8'h44);
    chk("R8 drained", level, 0);
  endtask

  task automatic t_flush();
    cyc(1'b1, 16'hA1A0, 1'b0, 1'b0);
    cyc(1'b1, 16'hA3A2, 1'b0, 1'b0);
    flush = 1'b1; #1;
    chk("R9 no req during flush", fetch_req, 0);
    cyc(1'b1, 16'h7777, 1'b1, 1'b1);
    chk("R9 level cleared", level, 0);
    chk("R9 rd_valid cleared", rd_valid, 0);
    chk("R9 underflow quiet", underflow, 0);
    chk("R9 req after flush", fetch_req, 1);
    cyc(1'b1, 16'h9988, 1'b0, 1'b0);
    chk("R9 fresh level", level, 2);
    read_expect("R9 fresh low", 8'h88);
    read_expect("R9 fresh high", 8'h99);
  endtask

  task automatic t_underflow();
    cyc(1'b0, 16'h0, 1'b1, 1'b0);
    chk("R10 pulse", underflow, 1);
    chk("R10 level stays", level, 0);
    cyc(1'b0, 16'h0, 1'b0, 1'b0);
    chk("R10 pulse ends", underflow, 0);
    cyc(1'b1, 16'h5150, 1'b0, 1'b0);
    read_expect("R10 queue intact", 8'h50);
    read_expect("R10 queue intact hi", 8'h51);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fill_valid = 1'b0; fill_word = '0;
    flush = 1'b0; opnd_pend = 1'b0; rd_req = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #3;
    t_reset();
    t_order();
    t_multi();
    t_room_drop();
    t_opnd();
    t_simul();
    t_flush();
    t_underflow();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule